// File: doc/BRIEF.md
# GF(2^89) Quadratic Root Finder

This block takes a field element `a` of GF(2^89) in polynomial basis, with reduction polynomial u^89 + u^38 + 1, and returns an element `z` with z^2 + z = a. This is the step of elliptic-curve point halving that needs a root of a quadratic. The equation has a root exactly when the absolute trace of `a` is zero. In that case the roots are `z` and `z + 1`, so they differ only in coefficient 0. The block always returns the root whose coefficient 0 is clear and leaves the other root to the caller, who gets it by flipping bit 0.

The datapath has a register stage on each side of a purely combinational GF(2)-linear network. An operand is accepted on any cycle in which `in_valid_i` is high, and its result comes out two rising edges later, together with a one-bit solvability flag. The network's per-bit masks are computed at elaboration from the field polynomial. A parameter chooses between a flat variant, in which each output bit is one XOR tree over the input bits, and a sequential ladder variant that is deeper and uses fewer gates per stage.

Top module: `gf89_qsolve`

## Requirements
- R1: While `rst_ni` is low, and after its release until the first result, `out_valid_o`, `z_o` and `solvable_o` are all zero.
- R2: An operand sampled at a rising edge with `in_valid_i` high makes `out_valid_o` high for exactly one cycle, starting after the second rising edge. A new operand can be accepted on every cycle, giving one result per cycle.
- R3: Bit i of `a_i` and of `z_o` is the coefficient of u^i. When trace(a) = 0, `z_o`^2 + `z_o` equals `a` reduced modulo u^89 + u^38 + 1.
- R4: Bit 0 of `z_o` is zero in every result.
- R5: `solvable_o` equals trace(a), inverted. For this polynomial trace(a) = a[0] xor a[51], so `solvable_o` is high exactly when bits 0 and 51 of the operand are equal.
- R6: When trace(a) = 1, `z_o` still satisfies `z_o`^2 + `z_o` = a xor 1, where xor 1 flips bit 0.
- R7: While `in_valid_i` is low, `a_i` has no effect. While `out_valid_o` is low, `z_o` and `solvable_o` keep the last result.
- R8: For a = 0 the result is `z_o` = 0 and `solvable_o` = 1. For a = u^2 + u (0x6) the result is `z_o` = u (0x2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand on `a_i` is valid this cycle |
| a_i | input | 89 | Right-hand side `a`, bit i = coefficient of u^i |
| out_valid_o | output | 1 | Result on `z_o` / `solvable_o` is new this cycle |
| z_o | output | 89 | Root with bit 0 cleared |
| solvable_o | output | 1 | High when trace(a) = 0 |

## Verification
The network has no internal state, so an error in its masks, its reduction taps or the root normalisation shows up at the output two edges after the offending operand. It appears as a `z_o` that no longer squares back to the operand, or as a set bit 0. A mistake in the trace taps inverts `solvable_o` on the operands that differ in bits 0 and 51. A fault in the valid pipeline shifts or drops `out_valid_o` in the first affected cycle and lets held results change while no output is pending.

// File: rtl/qsolve_pkg.sv
package qsolve_pkg;

  localparam int FIELD_W    = 89;
  localparam int TAP_POS    = 38;
  localparam int HALF_ITERS = (FIELD_W - 1) / 2;
  localparam int TRACE_HI   = FIELD_W - TAP_POS;
  localparam int SQ_W       = 2 * FIELD_W - 1;

  typedef logic [FIELD_W-1:0] elem_t;
  typedef logic [FIELD_W-1:0][FIELD_W-1:0] mat_t;

  // square in GF(2)[u] / (u^FIELD_W + u^TAP_POS + 1)
  function automatic elem_t gf_sq(elem_t x);
    logic [SQ_W-1:0] w;
    w = '0;
    for (int i = 0; i < FIELD_W; i++) w[2*i] = x[i];
    for (int d = SQ_W - 1; d >= FIELD_W; d--) begin
      if (w[d]) begin
        w[d]                     = 1'b0;
        w[d - FIELD_W + TAP_POS] = ~w[d - FIELD_W + TAP_POS];
        w[d - FIELD_W]           = ~w[d - FIELD_W];
      end
    end
    return w[FIELD_W-1:0];
  endfunction

  // sum of x^(4^k), k = 0..HALF_ITERS (odd field width)
  function automatic elem_t quarter_sum(elem_t x);
    elem_t h;
    h = x;
    for (int s = 0; s < HALF_ITERS; s++) h = gf_sq(gf_sq(h)) ^ x;
    return h;
  endfunction

  // rows[i][j]: input bit j feeds output bit i
  function automatic mat_t solve_rows();
    mat_t  rows;
    elem_t basis;
    elem_t col;
    rows = '0;
    for (int j = 0; j < FIELD_W; j++) begin
      basis    = '0;
      basis[j] = 1'b1;
      col      = quarter_sum(basis);
      for (int i = 0; i < FIELD_W; i++) rows[i][j] = col[i];
    end
    return rows;
  endfunction

  // trace of u^i as power sums of the roots of the trinomial (Newton)
  function automatic elem_t trace_mask();
    elem_t s;
    s    = '0;
    s[0] = 1'(FIELD_W % 2);
    for (int i = 1; i < FIELD_W; i++) begin
      if (i > TRACE_HI)       s[i] = s[i - TRACE_HI];
      else if (i == TRACE_HI) s[i] = 1'(TRACE_HI % 2);
      else                    s[i] = 1'b0;
    end
    return s;
  endfunction

endpackage

// File: rtl/qs_trace.sv
module qs_trace
  import qsolve_pkg::*;
(
  input  elem_t a_i,
  output logic  tr_o
);

  localparam elem_t TR_MASK = trace_mask();

  assign tr_o = ^(a_i & TR_MASK);

endmodule

// File: rtl/qs_solve_net.sv
module qs_solve_net
  import qsolve_pkg::*;
#(
  parameter bit FLAT = 1'b1
) (
  input  elem_t a_i,
  output elem_t z_o
);

  if (FLAT) begin : g_flat
    localparam mat_t ROWS = solve_rows();
    for (genvar i = 0; i < FIELD_W; i++) begin : g_bit
      assign z_o[i] = ^(a_i & ROWS[i]);
    end
  end else begin : g_ladder
    elem_t acc;
    always_comb begin
      acc = a_i;
      for (int s = 0; s < HALF_ITERS; s++) acc = gf_sq(gf_sq(acc)) ^ a_i;
    end
    assign z_o = acc;
  end

endmodule

// File: rtl/qs_root_pick.sv
module qs_root_pick
  import qsolve_pkg::*;
(
  input  elem_t z_i,
  output elem_t z_o
);

  // z and z+1 differ only in bit 0; keep the root with bit 0 clear
  assign z_o = {z_i[FIELD_W-1:1], 1'b0};

endmodule

// File: rtl/gf89_qsolve.sv
module gf89_qsolve
  import qsolve_pkg::*;
#(
  parameter bit FLAT_NET = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_valid_i,
  input  logic [FIELD_W-1:0] a_i,
  output logic               out_valid_o,
  output logic [FIELD_W-1:0] z_o,
  output logic               solvable_o
);

  elem_t a_q;
  logic  v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      v_q <= 1'b0;
    end else begin
      v_q <= in_valid_i;
      if (in_valid_i) a_q <= a_i;
    end
  end

  elem_t z_raw;
  elem_t z_pick;
  logic  tr_odd;

  qs_solve_net #(.FLAT(FLAT_NET)) u_net (
    .a_i (a_q),
    .z_o (z_raw)
  );

  qs_trace u_tr (
    .a_i  (a_q),
    .tr_o (tr_odd)
  );

  qs_root_pick u_pick (
    .z_i (z_raw),
    .z_o (z_pick)
  );

  elem_t z_q;
  logic  sol_q;
  logic  ov_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      z_q   <= '0;
      sol_q <= 1'b0;
      ov_q  <= 1'b0;
    end else begin
      ov_q <= v_q;
      if (v_q) begin
        z_q   <= z_pick;
        sol_q <= ~tr_odd;
      end
    end
  end

  assign out_valid_o = ov_q;
  assign z_o         = z_q;
  assign solvable_o  = sol_q;

endmodule

// File: rtl/qsolve_chk.sv
module qsolve_chk
  import qsolve_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               in_valid_i,
  input logic [FIELD_W-1:0] a_i,
  input logic               out_valid_o,
  input logic [FIELD_W-1:0] z_o,
  input logic               solvable_o
);

  a_r2_result_has_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(in_valid_i, 2));

  a_r2_source_has_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> ##1 out_valid_o);

  a_r3_root_squares_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && solvable_o) |-> ((gf_sq(z_o) ^ z_o) == $past(a_i, 2)));

  a_r4_low_bit_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !z_o[0]);

  a_r5_trace_taps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (solvable_o == ($past(a_i[0], 2) == $past(a_i[TRACE_HI], 2))));

  a_r6_odd_trace_root: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !solvable_o) |->
      ((gf_sq(z_o) ^ z_o) == ($past(a_i, 2) ^ elem_t'(1))));

  a_r7_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> ($stable(z_o) && $stable(solvable_o)));

endmodule

bind gf89_qsolve qsolve_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .a_i         (a_i),
  .out_valid_o (out_valid_o),
  .z_o         (z_o),
  .solvable_o  (solvable_o)
);

// File: tb/sim_gf89_qsolve.sv
module sim_gf89_qsolve;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 89;
  localparam int TAP        = 38;
  localparam int WATCHDOG   = 150000;

  typedef logic [W-1:0] fe_t;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic in_valid = 1'b0;
  fe_t  a_in = '0;
  logic out_valid;
  fe_t  z_out;
  logic solvable;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gf89_qsolve u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .in_valid_i  (in_valid),
    .a_i         (a_in),
    .out_valid_o (out_valid),
    .z_o         (z_out),
    .solvable_o  (solvable)
  );

  // reference arithmetic: shift-and-add multiply with per-step reduction
  function automatic fe_t xtime(fe_t v);
    fe_t r;
    r = v << 1;
    if (v[W-1]) begin
      r[TAP] = ~r[TAP];
      r[0]   = ~r[0];
    end
    return r;
  endfunction

  function automatic fe_t fmul(fe_t x, fe_t y);
    fe_t r;
    r = '0;
    for (int i = W - 1; i >= 0; i--) begin
      r = xtime(r);
      if (y[i]) r = r ^ x;
    end
    return r;
  endfunction

  function automatic logic ftrace(fe_t a);
    fe_t t;
    fe_t acc;
    t   = a;
    acc = a;
    for (int k = 1; k < W; k++) begin
      t   = fmul(t, t);
      acc = acc ^ t;
    end
    return acc[0];
  endfunction

  function automatic fe_t rnd_fe();
    logic [95:0] r;
    r = {$urandom(), $urandom(), $urandom()};
    return r[W-1:0];
  endfunction

  task automatic chk(input bit ok, input string tag, input fe_t act, input fe_t exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_bit(input string tag, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // checks a result already on the outputs against operand a
  task automatic check_result(input fe_t a, input string tag);
    logic tr;
    fe_t  lhs;
    fe_t  rhs;
    tr  = ftrace(a);
    lhs = fmul(z_out, z_out) ^ z_out;
    rhs = tr ? (a ^ fe_t'(1)) : a;
    chk_bit({tag, " R5 solvable"}, solvable, ~tr);
    chk_bit({tag, " R4 bit0"}, z_out[0], 1'b0);
    if (tr) chk(lhs === rhs, {tag, " R6 z^2+z=a+1"}, lhs, rhs);
    else    chk(lhs === rhs, {tag, " R3 z^2+z=a"}, lhs, rhs);
  endtask

  // single operand with latency probe
  task automatic run_one(input fe_t a, input string tag);
    @(negedge clk);
    a_in     = a;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    a_in     = ~a;
    chk_bit({tag, " R2 not yet"}, out_valid, 1'b0);
    @(negedge clk);
    chk_bit({tag, " R2 valid"}, out_valid, 1'b1);
    check_result(a, tag);
    @(negedge clk);
    chk_bit({tag, " R2 one pulse"}, out_valid, 1'b0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk_bit("R1 valid in reset", out_valid, 1'b0);
    chk(z_out === '0, "R1 z in reset", z_out, '0);
    chk_bit("R1 solvable in reset", solvable, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk_bit("R1 valid after release", out_valid, 1'b0);
    chk(z_out === '0, "R1 z after release", z_out, '0);
  endtask

  task automatic t_known();
    fe_t v;
    run_one('0, "zero");
    chk(z_out === '0, "R8 zero root", z_out, '0);
    chk_bit("R8 zero solvable", solvable, 1'b1);
    run_one(fe_t'(6), "u2+u");
    chk(z_out === fe_t'(2), "R8 root of u^2+u", z_out, fe_t'(2));
    run_one(fe_t'(1), "one");
    chk(z_out === '0, "R6 root for a=1", z_out, '0);
    v = '0; v[51] = 1'b1;
    run_one(v, "u51");
    chk_bit("R5 u^51 unsolvable", solvable, 1'b0);
    v[0] = 1'b1;
    run_one(v, "u51+1");
    chk_bit("R5 u^51+1 solvable", solvable, 1'b1);
    v = '0; v[W-1] = 1'b1;
    run_one(v, "u88");
  endtask

  task automatic t_random_solvable(input int n);
    for (int k = 0; k < n; k++) begin
      fe_t a;
      a = rnd_fe();
      if (ftrace(a)) a[0] = ~a[0];
      run_one(a, "rnd_even_trace R3");
    end
  endtask

  task automatic t_random_unsolvable(input int n);
    for (int k = 0; k < n; k++) begin
      fe_t a;
      a = rnd_fe();
      if (!ftrace(a)) a[0] = ~a[0];
      run_one(a, "rnd_odd_trace R6");
    end
  endtask

  task automatic t_stream(input int m);
    fe_t ops[32];
    for (int k = 0; k < m; k++) ops[k] = rnd_fe();
    for (int c = 0; c < m + 2; c++) begin
      @(negedge clk);
      if (c >= 2) begin
        chk_bit("R2 stream valid", out_valid, 1'b1);
        check_result(ops[c-2], "stream");
      end
      if (c < m) begin
        a_in     = ops[c];
        in_valid = 1'b1;
      end else begin
        in_valid = 1'b0;
      end
    end
    @(negedge clk);
    chk_bit("R2 stream drained", out_valid, 1'b0);
  endtask

  task automatic t_hold();
    fe_t  z_keep;
    logic s_keep;
    fe_t  a;
    a = rnd_fe();
    run_one(a, "hold_seed");
    z_keep = z_out;
    s_keep = solvable;
    for (int k = 0; k < 5; k++) begin
      a_in = rnd_fe();
      @(negedge clk);
      chk_bit("R7 idle valid", out_valid, 1'b0);
      chk(z_out === z_keep, "R7 z held", z_out, z_keep);
      chk_bit("R7 solvable held", solvable, s_keep);
    end
  endtask

  task automatic t_reset_midflight();
    fe_t a;
    a = rnd_fe();
    if (ftrace(a)) a[0] = ~a[0];
    @(negedge clk);
    a_in     = a;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n    = 1'b0;
    @(negedge clk);
    chk_bit("R1 midflight valid", out_valid, 1'b0);
    chk(z_out === '0, "R1 midflight z", z_out, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk_bit("R1 pending dropped", out_valid, 1'b0);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    #1;
    t_reset();
    t_known();
    t_random_solvable(30);
    t_random_unsolvable(10);
    t_stream(16);
    t_hold();
    t_reset_midflight();
    run_one(fe_t'(6), "post_reset");
    finish_run();
  end

endmodule